// File: doc/BRIEF.md
# Handshake-Bus Multicycle Accumulator CPU

This block is the control and register section of a small stored-program processor. It has two general registers A and B, a program counter and an instruction register. Memory, console and disk are reached over one shared command bus. The processor drives a command code, an address and a data word onto the bus. Each step it starts ends only when the responder on the other side returns an acknowledge code. Fetching an instruction is handled the same way: the fetch is a memory read that waits for its acknowledge.

Each opcode runs a fixed sequence of bus steps. Some opcodes use one step and some use two. Jumps and loads end with a synchronisation step that carries no transfer. The responders for memory, keyboard, display and disk are outside the block.

Top module: `hsb_cpu`

## Requirements
- R1: While reset is high and on leaving it, the bus shows command 1 (memory read) at address 0 with halted low. A, B, PC and IR are cleared, so a program that stores A and B before loading them writes zeros. Command codes on the bus are: 0 idle, 1 memory read, 2 memory write, 3 keyboard input, 4 console output, 5 disk open, 6 disk read, 7 disk close, 8 sync, 9 acknowledge (responder only).
- R2: An instruction word holds the opcode in bits 15:12 and the argument in bits 11:0. On the acknowledge of a fetch, IR takes the bus data and PC advances by one, so the next fetch reads the following address. The opcodes are: 0 halt, 1 jump, 2 jump-if-A-zero, 3 load A, 4 load B, 5 store A, 6 store B, 7 move A to the address held in B, 8 add, 9 input, 10 output, 11 file open, 12 file read, 13 file close.
- R3: A jump loads PC with the argument. A jump-if-zero does the same only when A is zero; otherwise execution continues in sequence. Both then issue a sync step and fetch after its acknowledge.
- R4: A load A or load B issues a memory read at the argument. On its acknowledge the register takes the data. A sync step follows, then the fetch.
- R5: A store A or store B issues a memory write of that register at the argument, then fetches after the acknowledge.
- R6: The move instruction issues a memory write of A at the address held in the low 12 bits of B.
- R7: Add places A+B (modulo 2^16) in A and issues the next fetch directly, with no bus step of its own.
- R8: Input or file read first issues its device command (3 or 6). On the acknowledge the processor captures the returned data, writes it to memory at the argument, and then fetches.
- R9: Output or file open first reads memory at the argument. It then issues command 4 or 6... specifically command 4 for output and command 5 for file open, carrying the word that was read, and then fetches.
- R10: File close issues command 7 and fetches after its acknowledge.
- R11: While a step awaits its acknowledge, the command, address and data outputs do not change.
- R12: Halt and the unused opcodes 14 and 15 raise the halted output and hold the bus idle until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rsp_cmd_i | input | 4 | Responder command code; 9 is acknowledge |
| rsp_data_i | input | 16 | Data returned by the responder |
| bus_cmd_o | output | 4 | Command issued by the processor |
| bus_addr_o | output | 12 | Address for the current step |
| bus_data_o | output | 16 | Data word for the current step |
| halted_o | output | 1 | High in the terminal halt state |

## Verification
The assertions assume that the responder never acknowledges while the processor shows the idle command. They also assume that one acknowledge completes exactly one step, so the processor leaves each wait state after a single acknowledge. The bench responder follows both rules. It answers only non-idle commands, after a chosen number of idle cycles, and it drops the acknowledge on the next cycle. Varying that latency exercises the hold-while-waiting behaviour without ever producing an acknowledge on an idle bus.

// File: rtl/hsb_pkg.sv
package hsb_pkg;

    localparam int OPC_W = 4;
    localparam int CMD_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OP_HALT   = 4'd0,
        OP_JUMP   = 4'd1,
        OP_JUMPZ  = 4'd2,
        OP_LOADA  = 4'd3,
        OP_LOADB  = 4'd4,
        OP_STOREA = 4'd5,
        OP_STOREB = 4'd6,
        OP_MOVEAB = 4'd7,
        OP_ADD    = 4'd8,
        OP_INPUT  = 4'd9,
        OP_OUTPUT = 4'd10,
        OP_FOPEN  = 4'd11,
        OP_FREAD  = 4'd12,
        OP_FCLOSE = 4'd13
    } opcode_e;

    typedef enum logic [CMD_W-1:0] {
        CMD_IDLE      = 4'd0,
        CMD_MEM_RD    = 4'd1,
        CMD_MEM_WR    = 4'd2,
        CMD_KEY_IN    = 4'd3,
        CMD_CON_OUT   = 4'd4,
        CMD_DSK_OPEN  = 4'd5,
        CMD_DSK_RD    = 4'd6,
        CMD_DSK_CLOSE = 4'd7,
        CMD_SYNC      = 4'd8,
        CMD_ACK       = 4'd9
    } cmd_e;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_LOAD,
        ST_CHAIN,
        ST_TAIL,
        ST_HALT
    } state_e;

    typedef struct packed {
        logic ir_ld;
        logic pc_inc;
        logic pc_jump;
        logic a_from_bus;
        logic b_from_bus;
        logic a_add;
    } dp_ctl_t;

    // Second bus command of the two-step device opcodes
    function automatic cmd_e chain_second(opcode_e op);
        case (op)
            OP_INPUT, OP_FREAD: return CMD_MEM_WR;
            OP_OUTPUT:          return CMD_CON_OUT;
            OP_FOPEN:           return CMD_DSK_OPEN;
            default:            return CMD_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/hsb_regs.sv
module hsb_regs import hsb_pkg::*; #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  dp_ctl_t           ctl,
    input  logic [DATA_W-1:0] bus_data_i,
    output logic [DATA_W-1:0] a_o,
    output logic [DATA_W-1:0] b_o,
    output logic [DATA_W-OPC_W-1:0] pc_o,
    output logic [DATA_W-1:0] ir_o
);
    localparam int ARG_W = DATA_W - OPC_W;

    logic [DATA_W-1:0] a_q, b_q, ir_q;
    logic [ARG_W-1:0]  pc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q  <= '0;
            b_q  <= '0;
            ir_q <= '0;
            pc_q <= '0;
        end else begin
            if (ctl.ir_ld)
                ir_q <= bus_data_i;
            if (ctl.pc_inc)
                pc_q <= pc_q + 1'b1;
            else if (ctl.pc_jump)
                pc_q <= ir_q[ARG_W-1:0];
            if (ctl.a_from_bus)
                a_q <= bus_data_i;
            else if (ctl.a_add)
                a_q <= a_q + b_q;
            if (ctl.b_from_bus)
                b_q <= bus_data_i;
        end
    end

    assign a_o  = a_q;
    assign b_o  = b_q;
    assign pc_o = pc_q;
    assign ir_o = ir_q;

    // R2
    fetch_pc_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.pc_inc |=> pc_q == ARG_W'($past(pc_q) + 1'b1));

    // R7
    add_result_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.a_add && !ctl.a_from_bus) |=> a_q == DATA_W'($past(a_q) + $past(b_q)));

endmodule

// File: rtl/hsb_seq.sv
module hsb_seq import hsb_pkg::*; #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CMD_W-1:0]  rsp_cmd_i,
    input  logic [DATA_W-1:0] rsp_data_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [DATA_W-OPC_W-1:0] pc_i,
    input  logic [DATA_W-1:0] ir_i,
    output dp_ctl_t           ctl_o,
    output logic [CMD_W-1:0]  cmd_o,
    output logic [DATA_W-OPC_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic              halted_o
);
    localparam int ARG_W = DATA_W - OPC_W;

    state_e            st_q;
    cmd_e              cmd_q, next_cmd_q;
    logic [ARG_W-1:0]  addr_q;
    logic [DATA_W-1:0] data_q;

    logic             ack;
    opcode_e          opc;
    logic [ARG_W-1:0] arg;

    assign ack = (rsp_cmd_i == CMD_ACK);
    assign opc = opcode_e'(ir_i[DATA_W-1 -: OPC_W]);
    assign arg = ir_i[ARG_W-1:0];

    always_comb begin
        ctl_o = '0;
        case (st_q)
            ST_FETCH: begin
                ctl_o.ir_ld  = ack;
                ctl_o.pc_inc = ack;
            end
            ST_DECODE: begin
                ctl_o.pc_jump = (opc == OP_JUMP) || (opc == OP_JUMPZ && a_i == '0);
                ctl_o.a_add   = (opc == OP_ADD);
            end
            ST_LOAD: begin
                ctl_o.a_from_bus = ack && (opc == OP_LOADA);
                ctl_o.b_from_bus = ack && (opc == OP_LOADB);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_FETCH;
            cmd_q      <= CMD_MEM_RD;
            next_cmd_q <= CMD_IDLE;
            addr_q     <= '0;
            data_q     <= '0;
        end else begin
            case (st_q)
                ST_FETCH: if (ack) begin
                    st_q  <= ST_DECODE;
                    cmd_q <= CMD_IDLE;
                end
                ST_DECODE: begin
                    next_cmd_q <= chain_second(opc);
                    addr_q     <= arg;
                    case (opc)
                        OP_JUMP, OP_JUMPZ: begin
                            cmd_q <= CMD_SYNC;
                            st_q  <= ST_TAIL;
                        end
                        OP_LOADA, OP_LOADB: begin
                            cmd_q <= CMD_MEM_RD;
                            st_q  <= ST_LOAD;
                        end
                        OP_STOREA: begin
                            cmd_q  <= CMD_MEM_WR;
                            data_q <= a_i;
                            st_q   <= ST_TAIL;
                        end
                        OP_STOREB: begin
                            cmd_q  <= CMD_MEM_WR;
                            data_q <= b_i;
                            st_q   <= ST_TAIL;
                        end
                        OP_MOVEAB: begin
                            cmd_q  <= CMD_MEM_WR;
                            addr_q <= b_i[ARG_W-1:0];
                            data_q <= a_i;
                            st_q   <= ST_TAIL;
                        end
                        OP_ADD: begin
                            cmd_q  <= CMD_MEM_RD;
                            addr_q <= pc_i;
                            st_q   <= ST_FETCH;
                        end
                        OP_INPUT: begin
                            cmd_q <= CMD_KEY_IN;
                            st_q  <= ST_CHAIN;
                        end
                        OP_FREAD: begin
                            cmd_q <= CMD_DSK_RD;
                            st_q  <= ST_CHAIN;
                        end
                        OP_OUTPUT, OP_FOPEN: begin
                            cmd_q <= CMD_MEM_RD;
                            st_q  <= ST_CHAIN;
                        end
                        OP_FCLOSE: begin
                            cmd_q <= CMD_DSK_CLOSE;
                            st_q  <= ST_TAIL;
                        end
                        default: begin
                            cmd_q <= CMD_IDLE;
                            st_q  <= ST_HALT;
                        end
                    endcase
                end
                ST_LOAD: if (ack) begin
                    cmd_q <= CMD_SYNC;
                    st_q  <= ST_TAIL;
                end
                ST_CHAIN: if (ack) begin
                    cmd_q  <= next_cmd_q;
                    data_q <= rsp_data_i;
                    st_q   <= ST_TAIL;
                end
                ST_TAIL: if (ack) begin
                    cmd_q  <= CMD_MEM_RD;
                    addr_q <= pc_i;
                    st_q   <= ST_FETCH;
                end
                default: st_q <= ST_HALT;
            endcase
        end
    end

    assign cmd_o    = cmd_q;
    assign addr_o   = addr_q;
    assign data_o   = data_q;
    assign halted_o = (st_q == ST_HALT);

    // R11
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q != ST_DECODE && st_q != ST_HALT && !ack)
        |=> ($stable(cmd_q) && $stable(addr_q) && $stable(data_q)));

    // R12
    halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        halted_o |=> (halted_o && cmd_q == CMD_IDLE));

    // R3
    jumpz_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_DECODE && opc == OP_JUMPZ && a_i != '0) |=> $stable(pc_i));

endmodule

// File: rtl/hsb_cpu.sv
module hsb_cpu import hsb_pkg::*; #(
    parameter int DATA_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [CMD_W-1:0]        rsp_cmd_i,
    input  logic [DATA_W-1:0]       rsp_data_i,
    output logic [CMD_W-1:0]        bus_cmd_o,
    output logic [DATA_W-OPC_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0]       bus_data_o,
    output logic                    halted_o
);
    localparam int ARG_W = DATA_W - OPC_W;

    dp_ctl_t           ctl;
    logic [DATA_W-1:0] reg_a, reg_b, reg_ir;
    logic [ARG_W-1:0]  reg_pc;

    hsb_regs #(.DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .bus_data_i (rsp_data_i),
        .a_o        (reg_a),
        .b_o        (reg_b),
        .pc_o       (reg_pc),
        .ir_o       (reg_ir)
    );

    hsb_seq #(.DATA_W(DATA_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .rsp_cmd_i  (rsp_cmd_i),
        .rsp_data_i (rsp_data_i),
        .a_i        (reg_a),
        .b_i        (reg_b),
        .pc_i       (reg_pc),
        .ir_i       (reg_ir),
        .ctl_o      (ctl),
        .cmd_o      (bus_cmd_o),
        .addr_o     (bus_addr_o),
        .data_o     (bus_data_o),
        .halted_o   (halted_o)
    );

endmodule

// File: tb/hsb_cpu_bench.sv
module hsb_cpu_bench;
    import hsb_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 5;
    // {a, b, expected sum}
    localparam logic [47:0] VECS [NVEC] = '{
        {16'h0003, 16'h0004, 16'h0007},
        {16'h1234, 16'h0001, 16'h1235},
        {16'h0005, 16'hFFFB, 16'h0000},
        {16'h8000, 16'h8000, 16'h0000},
        {16'hFFFF, 16'h0002, 16'h0001}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  rsp_cmd = 4'd0;
    logic [15:0] rsp_data = 16'd0;
    logic [3:0]  bus_cmd;
    logic [11:0] bus_addr;
    logic [15:0] bus_data;
    logic        halted;

    logic [15:0] mem [64];
    logic [3:0]  tr_cmd [64];
    logic [11:0] tr_addr [64];
    logic [15:0] tr_data [64];
    int          ntr = 0;
    int          lat = 0;
    int          wait_cnt = 0;
    int          viol = 0;
    logic        hold_prev = 1'b0;
    logic [31:0] prev_bus = '0;
    logic [15:0] out_val = '0, open_name = '0;
    int          total = 0, fails = 0, cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hsb_cpu u_hsb_cpu (
        .clk        (clk),
        .rst        (rst),
        .rsp_cmd_i  (rsp_cmd),
        .rsp_data_i (rsp_data),
        .bus_cmd_o  (bus_cmd),
        .bus_addr_o (bus_addr),
        .bus_data_o (bus_data),
        .halted_o   (halted)
    );

    // Responder: memory, keyboard, display and disk with a chosen latency
    always @(negedge clk) begin
        logic acked;
        acked = 1'b0;
        if (rst) begin
            rsp_cmd = CMD_IDLE; rsp_data = '0; ntr = 0; wait_cnt = 0;
            hold_prev = 1'b0; viol = 0;
        end else begin
            if (hold_prev && ({bus_cmd, bus_addr, bus_data} != prev_bus))
                viol++;
            rsp_cmd = CMD_IDLE;
            rsp_data = '0;
            if (bus_cmd != CMD_IDLE) begin
                if (wait_cnt >= lat) begin
                    acked = 1'b1;
                    wait_cnt = 0;
                    rsp_cmd = CMD_ACK;
                    case (bus_cmd)
                        CMD_MEM_RD:   rsp_data = mem[bus_addr[5:0]];
                        CMD_MEM_WR:   mem[bus_addr[5:0]] = bus_data;
                        CMD_KEY_IN:   rsp_data = 16'h4B1D;
                        CMD_DSK_RD:   rsp_data = 16'hD15C;
                        CMD_CON_OUT:  out_val = bus_data;
                        CMD_DSK_OPEN: open_name = bus_data;
                        default: ;
                    endcase
                    if (ntr < 64) begin
                        tr_cmd[ntr] = bus_cmd; tr_addr[ntr] = bus_addr; tr_data[ntr] = bus_data;
                    end
                    ntr++;
                end else begin
                    wait_cnt++;
                end
            end else begin
                wait_cnt = 0;
            end
            hold_prev = (bus_cmd != CMD_IDLE) && !acked;
            prev_bus = {bus_cmd, bus_addr, bus_data};
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            total++; fails++;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] arg);
        return {op, arg};
    endfunction

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) mem[i] = 16'h0;
    endtask

    task automatic run_prog(input int l);
        int n;
        lat = l;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        n = 0;
        while (!halted && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk("R12 program reached halt", {31'd0, halted}, 32'd1);
    endtask

    initial begin
        // R1: reset state
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset command", {28'd0, bus_cmd}, CMD_MEM_RD);
        chk("R1 reset address", {20'd0, bus_addr}, 32'd0);
        chk("R1 reset halted", {31'd0, halted}, 32'd0);

        // Table walk: loads, add, store, conditional jump, move
        for (int v = 0; v < NVEC; v++) begin
            logic [15:0] va, vb, vs;
            {va, vb, vs} = VECS[v];
            clear_mem();
            mem[0] = ins(OP_LOADA, 12'd20);
            mem[1] = ins(OP_LOADB, 12'd21);
            mem[2] = ins(OP_ADD, 12'd0);
            mem[3] = ins(OP_STOREA, 12'd22);
            mem[4] = ins(OP_JUMPZ, 12'd7);
            mem[5] = ins(OP_STOREB, 12'd23);
            mem[6] = ins(OP_HALT, 12'd0);
            mem[7] = ins(OP_MOVEAB, 12'd0);
            mem[8] = ins(OP_HALT, 12'd0);
            mem[20] = va; mem[21] = vb; mem[22] = 16'hFFFF; mem[23] = 16'hDEAD;
            run_prog(v % 3);
            chk("R7 sum stored by R5 store A", {16'd0, mem[22]}, {16'd0, vs});
            chk("R2 sequential fetch", {16'd0, tr_cmd[3], tr_addr[3]}, {16'd0, CMD_MEM_RD, 12'd1});
            chk("R4 load read address", {16'd0, tr_cmd[4], tr_addr[4]}, {16'd0, CMD_MEM_RD, 12'd21});
            chk("R4 sync after load", {28'd0, tr_cmd[2]}, CMD_SYNC);
            chk("R7 add has no bus step", {16'd0, tr_cmd[7], tr_addr[7]}, {16'd0, CMD_MEM_RD, 12'd3});
            chk("R3 sync after conditional jump", {28'd0, tr_cmd[10]}, CMD_SYNC);
            chk("R3 conditional jump target", {20'd0, tr_addr[11]}, (vs == 16'd0) ? 32'd7 : 32'd5);
            if (vs == 16'd0) begin
                chk("R6 move writes A at address in B", {16'd0, mem[vb[5:0]]}, 32'd0);
                chk("R3 skipped store leaves cell", {16'd0, mem[23]}, 32'hDEAD);
            end else begin
                chk("R5 store B", {16'd0, mem[23]}, {16'd0, vb});
            end
        end

        // Device program with a two-cycle responder latency
        clear_mem();
        mem[0]  = ins(OP_INPUT, 12'd30);
        mem[1]  = ins(OP_OUTPUT, 12'd30);
        mem[2]  = ins(OP_FOPEN, 12'd31);
        mem[3]  = ins(OP_FREAD, 12'd32);
        mem[4]  = ins(OP_FCLOSE, 12'd0);
        mem[5]  = ins(OP_JUMP, 12'd8);
        mem[6]  = ins(OP_HALT, 12'd0);
        mem[7]  = ins(OP_HALT, 12'd0);
        mem[8]  = ins(OP_STOREA, 12'd33);
        mem[9]  = ins(OP_STOREB, 12'd34);
        mem[10] = ins(OP_HALT, 12'd0);
        mem[31] = 16'h0F11; mem[33] = 16'h5555; mem[34] = 16'h5555;
        run_prog(2);
        chk("R8 input first command", {28'd0, tr_cmd[1]}, CMD_KEY_IN);
        chk("R8 input stored", {16'd0, mem[30]}, 32'h4B1D);
        chk("R9 output carries read word", {16'd0, out_val}, 32'h4B1D);
        chk("R9 open carries read word", {16'd0, open_name}, 32'h0F11);
        chk("R9 open command order", {24'd0, tr_cmd[7], tr_cmd[8]}, {24'd0, CMD_MEM_RD, CMD_DSK_OPEN});
        chk("R8 disk read first command", {28'd0, tr_cmd[10]}, CMD_DSK_RD);
        chk("R8 disk read stored", {16'd0, mem[32]}, 32'hD15C);
        chk("R10 close command", {28'd0, tr_cmd[13]}, CMD_DSK_CLOSE);
        chk("R10 fetch after close", {16'd0, tr_cmd[14], tr_addr[14]}, {16'd0, CMD_MEM_RD, 12'd5});
        chk("R3 jump sync step", {28'd0, tr_cmd[15]}, CMD_SYNC);
        chk("R3 jump target fetch", {20'd0, tr_addr[16]}, 32'd8);
        chk("R1 A cleared by reset", {16'd0, mem[33]}, 32'd0);
        chk("R1 B cleared by reset", {16'd0, mem[34]}, 32'd0);
        chk("R11 outputs held while waiting", viol, 32'd0);
        chk("R12 halt issues nothing further", ntr, 32'd21);

        // Unused opcode acts as halt
        clear_mem();
        mem[0] = ins(4'hE, 12'd5);
        mem[1] = ins(OP_STOREA, 12'd40);
        run_prog(1);
        repeat (10) @(negedge clk);
        chk("R12 unused opcode halted", {31'd0, halted}, 32'd1);
        chk("R12 bus idle after halt", {28'd0, bus_cmd}, CMD_IDLE);
        chk("R12 only the fetch was issued", ntr, 32'd1);

        summary();
        $finish;
    end

endmodule